// File: doc/BRIEF.md
# Branch History Rolling Buffer

This block keeps a ring of 64-bit branch records. A producer port pushes one record per cycle into the slot that holds the oldest record, so the ring always holds the most recent `DEPTH` records. An instruction-level request port offers two operations. The first reads one record by its age, where age 0 is the newest record. The second clears every record. Read results go out on a register-file result port.

Every request first passes an access gate. A clear hypervisor facility-enable input denies the request. So does a clear buffer-available bit while the core is in problem (user) state. A denied request runs neither its read nor its clear. It raises a facility-unavailable exception with a cause code, and a flag tells whether the hypervisor-level check caused it. Reads that are allowed still return zero in three cases: the age is past the buffer depth, the buffer feature is disabled, or the performance-monitor alert-enable bit is set.

A small state machine holds the outcome of the request from the previous cycle. Its states are `ST_IDLE`, `ST_READ_RSP`, `ST_CLEAR_RSP` and `ST_FAULT_RSP`. Each cycle the next state comes only from the current request. With no request it is `ST_IDLE`. A denied request gives `ST_FAULT_RSP`. An allowed read gives `ST_READ_RSP` and an allowed clear gives `ST_CLEAR_RSP`. Each response state drives its own output strobe for exactly one cycle.

Top module: `branch_hist_ring_top`

## Requirements
- R1: After reset every record reads as zero, and `rd_valid`, `clr_done`, `fu_exc` and `rd_data` are all low.
- R2: Each cycle with `rec_we` high stores `rec_data` over the oldest record. After more than `DEPTH` writes, only the last `DEPTH` records can be read back.
- R3: An allowed read with age k returns the record written k+1 writes before the current write position, so k=0 gives the newest record. `rd_valid` and `rd_data` appear one cycle after the request.
- R4: An allowed read whose 10-bit age is greater than or equal to `DEPTH` completes with `rd_valid` high and `rd_data` zero.
- R5: An allowed read returns zero with `rd_valid` high when `feat_en` is low or `alert_en` is high.
- R6: An allowed clear with `feat_en` high sets every record to zero. With `feat_en` low the clear completes but leaves the records unchanged. In both cases `clr_done` pulses one cycle after the request.
- R7: When `hyp_fac_en` is low, a read or a clear raises `fu_exc` with `fu_hyp` high one cycle later. It does not raise `rd_valid` or `clr_done` and does not change the records.
- R8: When `hyp_fac_en` is high, `user_mode` is high and `avail_en` is low, a request raises `fu_exc` with `fu_hyp` low. The hypervisor check has priority. With `user_mode` low, `avail_en` is ignored. Every exception carries `fu_cause` equal to the parameter `FU_CAUSE`, which defaults to 9.
- R9: A read in the same cycle as a record write returns the contents from before the write.
- R10: `req_op` encodes the operation: 0 is read by age, 1 is clear all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_we | input | 1 | Branch record write strobe |
| rec_data | input | 64 | Branch record to store |
| req_valid | input | 1 | Instruction request present |
| req_op | input | 1 | 0 read by age, 1 clear all |
| req_age | input | 10 | Age index for a read |
| user_mode | input | 1 | Core is in problem (user) state |
| hyp_fac_en | input | 1 | Hypervisor facility enable for the buffer |
| avail_en | input | 1 | Buffer-available control bit |
| feat_en | input | 1 | Buffer feature enabled |
| alert_en | input | 1 | Performance-monitor alert enable |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| clr_done | output | 1 | Clear completed |
| fu_exc | output | 1 | Facility-unavailable exception |
| fu_hyp | output | 1 | Exception came from the hypervisor-level check |
| fu_cause | output | 4 | Exception cause code |

## Verification
Every response (`rd_valid` with `rd_data`, `clr_done`, or `fu_exc` with its flag and cause) comes from one register stage, so it is due in the cycle after the edge that samples the request. Record writes land on that same edge, so a read after a write shows the write once one edge has passed. The bench drives inputs on the falling edge and samples each response on the next falling edge, half a cycle after the rising edge that produced it. After a clear or a denied request, the bench reads the records back through the ordinary read request to show whether the operation had any effect.

// File: rtl/branch_hist_pkg.sv
package branch_hist_pkg;

    localparam int REC_W = 64;
    localparam int AGE_W = 10;
    localparam int CAUSE_W = 4;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_CLEAR = 1'b1
    } req_op_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_RSP  = 2'd1,
        ST_CLEAR_RSP = 2'd2,
        ST_FAULT_RSP = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/branch_hist_store.sv
module branch_hist_store
    import branch_hist_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    input  logic             clr_en,
    input  logic [AGE_W-1:0] rd_age,
    output logic             rd_in_range,
    output logic [REC_W-1:0] rd_rec
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SUM_W = AGE_W + 2;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [REC_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [SUM_W-1:0] pos_sum;
    logic [PTR_W-1:0] rd_idx;

    // One register per slot; a write to the targeted slot wins over clear.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_ptr_q == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end else if (clr_en) begin
                slot_q[g] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    // Position = (write pointer - age - 1) mod DEPTH, computed without negatives.
    always_comb begin
        rd_in_range = (SUM_W'(rd_age) < SUM_W'(DEPTH));
        pos_sum = SUM_W'(wr_ptr_q) + SUM_W'(DEPTH) - SUM_W'(rd_age) - SUM_W'(1);
        if (pos_sum >= SUM_W'(DEPTH)) begin
            pos_sum = pos_sum - SUM_W'(DEPTH);
        end
        rd_idx = rd_in_range ? PTR_W'(pos_sum) : '0;
        rd_rec = slot_q[rd_idx];
    end

    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_ptr_q == (($past(wr_ptr_q) == LAST_SLOT) ? '0 : $past(wr_ptr_q) + 1'b1)));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_ptr_q));

    assert_clear_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> (slot_q[0] == '0));

endmodule

// File: rtl/branch_hist_gate.sv
module branch_hist_gate (
    input  logic req_valid,
    input  logic user_mode,
    input  logic hyp_fac_en,
    input  logic avail_en,
    output logic deny,
    output logic deny_hyp
);
    logic hyp_block;
    logic priv_block;

    always_comb begin
        hyp_block  = !hyp_fac_en;
        priv_block = user_mode && !avail_en;
        deny       = req_valid && (hyp_block || priv_block);
        deny_hyp   = req_valid && hyp_block;
    end

endmodule

// File: rtl/branch_hist_ring_top.sv
module branch_hist_ring_top
    import branch_hist_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter logic [CAUSE_W-1:0] FU_CAUSE = 4'd9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_we,
    input  logic [REC_W-1:0]   rec_data,
    input  logic               req_valid,
    input  logic               req_op,
    input  logic [AGE_W-1:0]   req_age,
    input  logic               user_mode,
    input  logic               hyp_fac_en,
    input  logic               avail_en,
    input  logic               feat_en,
    input  logic               alert_en,
    output logic               rd_valid,
    output logic [REC_W-1:0]   rd_data,
    output logic               clr_done,
    output logic               fu_exc,
    output logic               fu_hyp,
    output logic [CAUSE_W-1:0] fu_cause
);
    rsp_state_e       state_q, state_d;
    req_op_e          op;
    logic             deny, deny_hyp;
    logic             do_read, do_clear;
    logic             age_ok;
    logic [REC_W-1:0] ring_rec;
    logic [REC_W-1:0] rd_q;
    logic             hyp_q;

    assign op       = req_op_e'(req_op);
    assign do_read  = req_valid && !deny && (op == OP_READ);
    assign do_clear = req_valid && !deny && (op == OP_CLEAR);

    branch_hist_gate u_gate (
        .req_valid  (req_valid),
        .user_mode  (user_mode),
        .hyp_fac_en (hyp_fac_en),
        .avail_en   (avail_en),
        .deny       (deny),
        .deny_hyp   (deny_hyp)
    );

    branch_hist_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (rec_we),
        .wr_data     (rec_data),
        .clr_en      (do_clear && feat_en),
        .rd_age      (req_age),
        .rd_in_range (age_ok),
        .rd_rec      (ring_rec)
    );

    // Next state: decided by the request of this cycle alone.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (deny) begin
                state_d = ST_FAULT_RSP;
            end else if (op == OP_READ) begin
                state_d = ST_READ_RSP;
            end else begin
                state_d = ST_CLEAR_RSP;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Response payload captured with the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            hyp_q <= 1'b0;
        end else begin
            if (do_read) begin
                rd_q <= (!age_ok || !feat_en || alert_en) ? '0 : ring_rec;
            end
            if (req_valid && deny) begin
                hyp_q <= deny_hyp;
            end
        end
    end

    // Outputs: one process decoding the state.
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        clr_done = 1'b0;
        fu_exc   = 1'b0;
        fu_hyp   = 1'b0;
        fu_cause = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_RSP: begin
                rd_valid = 1'b1;
                rd_data  = rd_q;
            end
            ST_CLEAR_RSP: clr_done = 1'b1;
            ST_FAULT_RSP: begin
                fu_exc   = 1'b1;
                fu_hyp   = hyp_q;
                fu_cause = FU_CAUSE;
            end
            default: ;
        endcase
    end

    assert_one_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, clr_done, fu_exc}));

    assert_hyp_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hyp_fac_en) |=> (fu_exc && fu_hyp && !rd_valid && !clr_done));

    assert_priv_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hyp_fac_en && user_mode && !avail_en) |=> (fu_exc && !fu_hyp));

    assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fu_exc |-> (fu_cause == FU_CAUSE));

    assert_oob_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && hyp_fac_en && (!user_mode || avail_en)
         && (int'(req_age) >= DEPTH)) |=> (rd_valid && (rd_data == '0)));

    assert_alert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && hyp_fac_en && (!user_mode || avail_en)
         && (alert_en || !feat_en)) |=> (rd_valid && (rd_data == '0)));

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rd_valid || clr_done || fu_exc));

endmodule

// File: tb/branch_hist_ring_top_tb.sv
module branch_hist_ring_top_tb;
    localparam int DEPTH = 32;
    localparam logic [3:0] CAUSE = 4'd9;
    localparam int NVEC = 11;
    // {age[9:0], user, hyp, avail, feat, alert, kind[1:0]}
    // kind: 0 data, 1 zero, 2 hypervisor fault, 3 privilege fault
    localparam logic [16:0] VEC [NVEC] = '{
        {10'd0,    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0},
        {10'd5,    1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        {10'd31,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        {10'd32,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
        {10'd1023, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1},
        {10'd3,    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
        {10'd3,    1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1},
        {10'd2,    1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
        {10'd2,    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2},
        {10'd2,    1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3},
        {10'd7,    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_we = 1'b0;
    logic [63:0] rec_data = '0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [9:0]  req_age = '0;
    logic        user_mode = 1'b0;
    logic        hyp_fac_en = 1'b1;
    logic        avail_en = 1'b1;
    logic        feat_en = 1'b1;
    logic        alert_en = 1'b0;
    logic        rd_valid, clr_done, fu_exc, fu_hyp;
    logic [63:0] rd_data;
    logic [3:0]  fu_cause;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [63:0] mdl [DEPTH];
    int mwp = 0;

    always #10 clk = ~clk;

    branch_hist_ring_top #(.DEPTH(DEPTH), .FU_CAUSE(CAUSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .rec_we(rec_we), .rec_data(rec_data),
        .req_valid(req_valid), .req_op(req_op), .req_age(req_age),
        .user_mode(user_mode), .hyp_fac_en(hyp_fac_en), .avail_en(avail_en),
        .feat_en(feat_en), .alert_en(alert_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .clr_done(clr_done), .fu_exc(fu_exc),
        .fu_hyp(fu_hyp), .fu_cause(fu_cause)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_age(input int k);
        return mdl[((mwp - k - 1) % DEPTH + DEPTH) % DEPTH];
    endfunction

    task automatic push(input logic [63:0] v);
        rec_we = 1'b1;
        rec_data = v;
        @(negedge clk);
        rec_we = 1'b0;
        mdl[mwp] = v;
        mwp = (mwp + 1) % DEPTH;
    endtask

    // Issue a request at a falling edge; on return the response is sampled.
    task automatic request(input logic op, input logic [9:0] age);
        req_valid = 1'b1;
        req_op = op;
        req_age = age;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_expect(input int k, input logic [63:0] exp, input string req);
        request(1'b0, 10'(k));
        check(rd_valid === 1'b1 && fu_exc === 1'b0, req, {63'd0, rd_valid}, 64'd1);
        check(rd_data === exp, req, rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check({rd_valid, clr_done, fu_exc} === 3'b000 && rd_data === '0, "R1",
              {61'd0, rd_valid, clr_done, fu_exc}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rd_valid, clr_done, fu_exc} === 3'b000, "R1 idle",
              {61'd0, rd_valid, clr_done, fu_exc}, 64'd0);
        read_expect(0, 64'd0, "R1 record zero");
        read_expect(31, 64'd0, "R1 oldest zero");

        // R2: 40 writes wrap the ring
        for (int i = 0; i < 40; i++) push(64'hC0DE_0000_0000_0000 | 64'(i * 3 + 1));
        read_expect(0, 64'hC0DE_0000_0000_0000 | 64'(39 * 3 + 1), "R2 newest");
        read_expect(31, 64'hC0DE_0000_0000_0000 | 64'(8 * 3 + 1), "R2 oldest kept");

        // Vector table: R3, R4, R5, R7, R8, R10 (op 0 is read)
        for (int v = 0; v < NVEC; v++) begin
            logic [63:0] exp;
            int k;
            k = int'(VEC[v][16:7]);
            user_mode  = VEC[v][6];
            hyp_fac_en = VEC[v][5];
            avail_en   = VEC[v][4];
            feat_en    = VEC[v][3];
            alert_en   = VEC[v][2];
            request(1'b0, VEC[v][16:7]);
            case (VEC[v][1:0])
                2'd0, 2'd1: begin
                    exp = (VEC[v][1:0] == 2'd0) ? model_age(k) : 64'd0;
                    check(rd_valid === 1'b1 && fu_exc === 1'b0, "R3 R10 valid",
                          {63'd0, rd_valid}, 64'd1);
                    check(rd_data === exp, "R3 R4 R5 data", rd_data, exp);
                end
                default: begin
                    check(fu_exc === 1'b1 && rd_valid === 1'b0, "R7 R8 fault",
                          {62'd0, fu_exc, rd_valid}, 64'd2);
                    check(fu_hyp === (VEC[v][1:0] == 2'd2), "R8 fault kind",
                          {63'd0, fu_hyp}, {63'd0, VEC[v][1:0] == 2'd2});
                    check(fu_cause === CAUSE, "R8 cause", {60'd0, fu_cause}, {60'd0, CAUSE});
                end
            endcase
        end
        user_mode = 1'b0; hyp_fac_en = 1'b1; avail_en = 1'b1;
        feat_en = 1'b1; alert_en = 1'b0;

        // R9: write and read in the same cycle see the pre-write record
        begin
            logic [63:0] old_newest;
            old_newest = model_age(0);
            rec_we = 1'b1; rec_data = 64'h1234_5678_9ABC_DEF0;
            req_valid = 1'b1; req_op = 1'b0; req_age = 10'd0;
            @(negedge clk);
            rec_we = 1'b0; req_valid = 1'b0;
            mdl[mwp] = 64'h1234_5678_9ABC_DEF0; mwp = (mwp + 1) % DEPTH;
            check(rd_data === old_newest, "R9 pre-write", rd_data, old_newest);
            read_expect(0, 64'h1234_5678_9ABC_DEF0, "R9 R2 after write");
        end

        // R7: clear denied by the hypervisor check has no effect
        hyp_fac_en = 1'b0;
        request(1'b1, 10'd0);
        check(fu_exc === 1'b1 && fu_hyp === 1'b1 && clr_done === 1'b0, "R7 clear denied",
              {61'd0, fu_exc, fu_hyp, clr_done}, 64'd6);
        hyp_fac_en = 1'b1;
        read_expect(4, model_age(4), "R7 records kept");

        // R6: clear with feature disabled leaves records
        feat_en = 1'b0;
        request(1'b1, 10'd0);
        check(clr_done === 1'b1, "R6 R10 clear done", {63'd0, clr_done}, 64'd1);
        feat_en = 1'b1;
        read_expect(2, model_age(2), "R6 no-effect clear");

        // R6: clear with feature enabled zeroes every record
        request(1'b1, 10'd0);
        check(clr_done === 1'b1 && rd_valid === 1'b0, "R6 clear done",
              {62'd0, clr_done, rd_valid}, 64'd2);
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        for (int k = 0; k < DEPTH; k++) read_expect(k, 64'd0, "R6 zeroed");
        push(64'hFEED_0000_0000_0042);
        read_expect(0, 64'hFEED_0000_0000_0042, "R6 R2 write after clear");
        read_expect(1, 64'd0, "R6 older still zero");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule